// File: doc/BRIEF.md
# Three-Leg Half-Bridge Gate Sequencer

This block turns per-leg "upper on" and "lower on" requests into gate enables for three independent half bridges. Each request pair is brought into the clock domain through a synchronizer chain. Each leg then runs a small state machine with its own countdown. That state machine refuses to turn on either switch while both requests are high. It holds a newly requested switch off until a programmable number of clock cycles has passed with both switches of that leg off.

Three independent kill sources force every gate enable low, which leaves all three outputs floating. These are two disable inputs and an undervoltage lockout input. By default the kill acts combinationally, in the same cycle, so the shutdown path is faster than the command path. A parameter can select a single registered stage for this path instead. The kill also passes through its own synchronizer and parks every leg's state machine in the off state. Normal operation then restarts with a full dead-time wait.

Top module: `tri_leg_gate_ctrl`

## Requirements
- R1: While reset is asserted, every upper and lower gate output is low. Each leg's countdown is loaded full, so no gate can rise within DEAD_CYC+1 clock edges after reset is released.
- R2: A leg whose upper and lower requests are both high (after synchronization) has both gates low one edge later, and they stay low while the overlap lasts. The two gates of one leg are never high together.
- R3: Dropping the request of a switch that is on turns its gate off on the third rising edge after the input change: two synchronizer edges plus one edge in the leg.
- R4: A request to turn a switch on, made to a leg that has had both gates off for at least DEAD_CYC cycles, raises that gate on the third rising edge after the input change.
- R5: After either gate of a leg falls, neither gate of that leg rises until DEAD_CYC+1 rising edges later. With the default DEAD_CYC of 8, a gate that falls at edge E can rise at edge E+9 at the earliest. This holds both for the opposite switch and for the same switch.
- R6: When any of dis_a, dis_b or uv_lock is high, all six gate outputs are low and float_o is high in the same cycle. When all three are low, float_o is low.
- R7: While a kill source is high, changes to the requests raise no gate.
- R8: After the last kill source falls at a given input change, gates stay low through edge DEAD_CYC+2 after that change. A gate whose request is still held then rises at edge DEAD_CYC+3.
- R9: Each leg acts only on its own requests. Switching one leg leaves the gates of the other legs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | NUM_LEGS | Per-leg request for the upper switch, asynchronous |
| dn_req | input | NUM_LEGS | Per-leg request for the lower switch, asynchronous |
| dis_a | input | 1 | Kill source A, active high |
| dis_b | input | 1 | Kill source B, active high |
| uv_lock | input | 1 | Undervoltage lockout kill, active high |
| up_gate | output | NUM_LEGS | Upper switch gate enable per leg |
| dn_gate | output | NUM_LEGS | Lower switch gate enable per leg |
| float_o | output | 1 | High while the outputs are forced off by a kill source |

## Verification
The in-line properties assume that the request and kill inputs are steady around each rising edge. They also assume that a request stays high long enough to pass the synchronizer chain, so that the synchronized view of it is a clean level. The stimulus changes every input only on falling edges and holds every level for several cycles, except for one deliberate single-cycle gap in a request. It never releases a kill source while another is still high in a way that would mix the release timings of the three sources.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

   // requested or driven switch pair of one leg
   typedef struct packed {
      logic up;
      logic dn;
   } sw_pair_t;

   typedef enum logic [1:0] {
      LEG_OFF = 2'b00,
      LEG_UP  = 2'b01,
      LEG_DN  = 2'b10
   } leg_state_e;

   // a request pair maps to the wanted state; overlap means off
   function automatic leg_state_e wanted_state(input sw_pair_t r);
      leg_state_e s;
      if (r.up && !r.dn)      s = LEG_UP;
      else if (r.dn && !r.up) s = LEG_DN;
      else                    s = LEG_OFF;
      return s;
   endfunction

   function automatic sw_pair_t state_to_pair(input leg_state_e s);
      sw_pair_t p;
      p.up = (s == LEG_UP);
      p.dn = (s == LEG_DN);
      return p;
   endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
   parameter int   WIDTH   = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam logic [WIDTH-1:0] RST_WORD = {WIDTH{RST_VAL}};

   if (WIDTH < 1) begin : g_bad_width
      $error("hbg_sync: WIDTH must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("hbg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_WORD;
      else        stg[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[k] <= RST_WORD;
         else        stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
   import hbg_pkg::*;
#(
   parameter int DEAD_CYC = 8,
   localparam int CW      = $clog2(DEAD_CYC + 1)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     kill_s,
   input  sw_pair_t req,
   output sw_pair_t drv
);

   localparam logic [CW-1:0] CNT_FULL = CW'(DEAD_CYC);
   localparam logic [CW:0]   RUN_MIN  = (CW+1)'(DEAD_CYC);
   localparam logic [CW:0]   RUN_SAT  = (CW+1)'(DEAD_CYC + 1);

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("hbg_leg: DEAD_CYC must be at least 1");
   end

   leg_state_e    st_q, st_d, want;
   logic [CW-1:0] cnt_q;

   assign want = wanted_state(req);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         LEG_UP:  if (want != LEG_UP) st_d = LEG_OFF;
         LEG_DN:  if (want != LEG_DN) st_d = LEG_OFF;
         default: if (cnt_q == '0)    st_d = want;
      endcase
      if (kill_s) st_d = LEG_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LEG_OFF;
      else        st_q <= st_d;
   end

   // countdown reloads while a switch is on or killed, runs while both are off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= CNT_FULL;
      else if (kill_s || st_q != LEG_OFF)  cnt_q <= CNT_FULL;
      else if (cnt_q != '0)                cnt_q <= cnt_q - 1'b1;
   end

   assign drv = state_to_pair(st_q);

   // checker-side count of consecutive both-off cycles, saturating
   logic [CW:0] off_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                off_run <= '0;
      else if (st_q != LEG_OFF)  off_run <= '0;
      else if (off_run < RUN_SAT) off_run <= off_run + 1'b1;
   end

   // R2
   overlap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req.up && req.dn) |=> (st_q == LEG_OFF));

   // R3
   up_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LEG_UP && !(req.up && !req.dn)) |=> (st_q != LEG_UP));

   // R3
   dn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LEG_DN && !(req.dn && !req.up)) |=> (st_q != LEG_DN));

   // R5
   dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LEG_OFF && st_d != LEG_OFF) |-> (off_run >= RUN_MIN));

   // R7
   kill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_s |=> (st_q == LEG_OFF));

endmodule

// File: rtl/tri_leg_gate_ctrl.sv
module tri_leg_gate_ctrl
   import hbg_pkg::*;
#(
   parameter int NUM_LEGS       = 3,
   parameter int DEAD_CYC       = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit DIS_REGISTERED = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_LEGS-1:0] up_req,
   input  logic [NUM_LEGS-1:0] dn_req,
   input  logic                dis_a,
   input  logic                dis_b,
   input  logic                uv_lock,
   output logic [NUM_LEGS-1:0] up_gate,
   output logic [NUM_LEGS-1:0] dn_gate,
   output logic                float_o
);

   localparam int REQ_W = 2 * NUM_LEGS;

   if (NUM_LEGS < 1) begin : g_bad_legs
      $error("tri_leg_gate_ctrl: NUM_LEGS must be at least 1");
   end

   logic             kill_raw, kill_s, kill_mask;
   logic [REQ_W-1:0] req_s;

   assign kill_raw = dis_a | dis_b | uv_lock;

   hbg_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dn_req, up_req}),
      .q     (req_s)
   );

   hbg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_kill_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (kill_raw),
      .q     (kill_s)
   );

   // output mask: same cycle, or a single registered stage
   if (DIS_REGISTERED) begin : g_mask_reg
      logic mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mask_q <= 1'b1;
         else        mask_q <= kill_raw;
      end
      assign kill_mask = mask_q | kill_raw;
   end else begin : g_mask_comb
      assign kill_mask = kill_raw;
   end

   for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      sw_pair_t leg_req, leg_drv;
      assign leg_req.up = req_s[g];
      assign leg_req.dn = req_s[NUM_LEGS + g];

      hbg_leg #(.DEAD_CYC(DEAD_CYC)) i_leg (
         .clk    (clk),
         .rst_n  (rst_n),
         .kill_s (kill_s),
         .req    (leg_req),
         .drv    (leg_drv)
      );

      assign up_gate[g] = leg_drv.up & ~kill_mask;
      assign dn_gate[g] = leg_drv.dn & ~kill_mask;
   end

   assign float_o = kill_mask;

   // R6
   kill_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_raw |-> (up_gate == '0 && dn_gate == '0 && float_o));

   // R2
   leg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_gate & dn_gate) == '0);

endmodule

// File: tb/test_tri_leg_gate_ctrl.sv
`timescale 1ns/1ps
module test_tri_leg_gate_ctrl;

   localparam int NL = 3;
   localparam int D  = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NL-1:0] up_req, dn_req, up_gate, dn_gate;
   logic          dis_a, dis_b, uv_lock, float_o;

   always #2 clk = ~clk;

   tri_leg_gate_ctrl #(.NUM_LEGS(NL), .DEAD_CYC(D)) i_tri_leg_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req),
      .dis_a(dis_a), .dis_b(dis_b), .uv_lock(uv_lock),
      .up_gate(up_gate), .dn_gate(dn_gate), .float_o(float_o)
   );

   typedef struct {
      int    cyc;
      int    leg;   // -1 selects float_o, compared with up
      bit    up;
      bit    dn;
      string req;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    n_chk = 0;
   int    n_err = 0;
   bit    done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(int off, int leg, bit up, bit dn, string req);
      item_t it;
      it.cyc = cyc + off; it.leg = leg; it.up = up; it.dn = dn; it.req = req;
      sb.push_back(it);
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_leg(int leg, bit up, bit dn);
      up_req[leg] = up;
      dn_req[leg] = dn;
   endtask

   task automatic set_src(int s, bit v);
      case (s)
         0:       dis_a   = v;
         1:       dis_b   = v;
         default: uv_lock = v;
      endcase
   endtask

   // monitor: pops due items after each falling edge
   always @(negedge clk) begin
      #1;
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         item_t it;
         it = sb.pop_front();
         n_chk++;
         if (it.cyc != cyc) begin
            n_err++;
            $display("FAIL %s: item for cycle %0d seen at %0d (actual late, expected on time)",
                     it.req, it.cyc, cyc);
         end else if (it.leg < 0) begin
            if (float_o !== it.up) begin
               n_err++;
               $display("FAIL %s: float_o actual %0b expected %0b", it.req, float_o, it.up);
            end
         end else if (up_gate[it.leg] !== it.up || dn_gate[it.leg] !== it.dn) begin
            n_err++;
            $display("FAIL %s: leg %0d cycle %0d actual up=%0b dn=%0b expected up=%0b dn=%0b",
                     it.req, it.leg, cyc, up_gate[it.leg], dn_gate[it.leg], it.up, it.dn);
         end
      end
      if (rst_n) begin
         n_chk++;
         if ((up_gate & dn_gate) != '0) begin
            n_err++;
            $display("FAIL R2: both gates high actual up=%b dn=%b expected no overlap",
                     up_gate, dn_gate);
         end
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; up_req = '0; dn_req = '0;
      dis_a = 1'b0; dis_b = 1'b0; uv_lock = 1'b0;
      tick(3);
      // R1: gates low in reset
      for (int l = 0; l < NL; l++) expect_at(0, l, 0, 0, "R1");
      tick(1);
      rst_n = 1'b1;
      // R1: a request right after reset waits out the loaded countdown
      set_leg(0, 1, 0);
      expect_at(3, 0, 0, 0, "R1");
      tick(D + 12);
      set_leg(0, 0, 0);
      tick(D + 8);

      // R4: turn-on from a long idle leg
      set_leg(0, 1, 0);
      expect_at(2, 0, 0, 0, "R4");
      expect_at(3, 0, 1, 0, "R4");
      tick(6);

      // R3 then R5: swap to the lower switch
      set_leg(0, 0, 1);
      expect_at(2, 0, 1, 0, "R3");
      expect_at(3, 0, 0, 0, "R3");
      expect_at(3 + D, 0, 0, 0, "R5");
      expect_at(4 + D, 0, 0, 1, "R5");
      tick(D + 8);

      // R2: overlapping requests
      set_leg(0, 1, 1);
      expect_at(2, 0, 0, 1, "R2");
      expect_at(3, 0, 0, 0, "R2");
      expect_at(D + 6, 0, 0, 0, "R2");
      tick(D + 8);
      set_leg(0, 1, 0);
      expect_at(3, 0, 1, 0, "R4");
      tick(6);

      // R9: other legs switch, leg 0 unchanged
      set_leg(1, 0, 1);
      expect_at(3, 0, 1, 0, "R9");
      expect_at(3, 1, 0, 1, "R9");
      tick(6);
      set_leg(2, 1, 0);
      expect_at(3, 1, 0, 1, "R9");
      expect_at(3, 2, 1, 0, "R9");
      tick(6);

      // R5: one-cycle gap in the same request still costs a dead time
      set_leg(2, 0, 0);
      expect_at(3, 2, 0, 0, "R5");
      expect_at(3 + D, 2, 0, 0, "R5");
      expect_at(4 + D, 2, 1, 0, "R5");
      tick(1);
      set_leg(2, 1, 0);
      tick(D + 8);
      expect_at(0, 0, 1, 0, "R9");
      tick(1);

      // R6, R7, R8 for each kill source
      for (int s = 0; s < 3; s++) begin
         set_src(s, 1);
         expect_at(0, -1, 1, 0, "R6");
         for (int l = 0; l < NL; l++) expect_at(0, l, 0, 0, "R6");
         tick(2);
         set_leg(0, 0, 1); set_leg(1, 1, 0); set_leg(2, 0, 1);
         for (int l = 0; l < NL; l++) expect_at(4, l, 0, 0, "R7");
         tick(6);
         set_leg(0, 1, 0); set_leg(1, 0, 1); set_leg(2, 1, 0);
         tick(6);
         set_src(s, 0);
         expect_at(0, -1, 0, 0, "R6");
         for (int l = 0; l < NL; l++) expect_at(2 + D, l, 0, 0, "R8");
         expect_at(3 + D, 0, 1, 0, "R8");
         expect_at(3 + D, 1, 0, 1, "R8");
         expect_at(3 + D, 2, 1, 0, "R8");
         tick(D + 8);
      end

      tick(4);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule